// File: doc/BRIEF.md
# Dual-Issue Pairing Checker

This block sits in the issue stage of an in-order pipeline that can start two instructions per cycle. Every cycle it inspects a window holding the next two predecoded instructions in program order and decides whether both may issue together or whether only the older one goes. Each instruction arrives already classified. It carries a class code, a destination and two source register numbers with a bit per operand saying which register file (integer or floating point) it names, and a small set of behaviour flags.

The verdict comes from a first/second class compatibility matrix and then from a set of operand hazards: read-after-write, a floating-point load against a floating-point operation on the other half or the same target, and carry/borrow producer against consumer. There is one allowed case of forwarding a floating-point result straight into a store. Two pieces of history are kept across cycles. One marks that the next issue is a branch delay slot. The other marks that the next window starts at the target of a taken branch. Both force single issue when they apply.

The window handshake passes straight through to the issue side. `iss_valid` mirrors `win_valid`, and `win_ready` mirrors `iss_ready`. When the handshake completes, one instruction is consumed if `iss_dual` is low and two if it is high.

Top module: `pair_issue_gate`

## Requirements
- R1: `iss_valid` equals `win_valid` and `win_ready` equals `iss_ready` in the same cycle. `iss_dual` is high only when `win_valid` and `s1_valid` are both high and `s1_pc` equals `s0_pc + 1` (word addresses, modulo 2^PC_W).
- R2: Class codes are 0 FP operation, 1 load/store, 2 integer ALU, 3 shift/extract/deposit, 4 may-nullify, 5 vectored branch, 6 other branch, 7 FP test/status, 8 system; codes 9..15 never pair. A pair needs the second class to be allowed for the first. After FP op the second may be 1,2,3,4,5,6. After load/store it may be 0,2,3,4,6. After ALU it may be 0,1,2,3,4,6,7. After shift it may be 0,1,2,7. After may-nullify it may be 0. Any other first class never pairs, so two load/stores never pair.
- R3: A system instruction (class 8) in either slot never pairs.
- R4: The pair is rejected when slot 0 writes a register (`regctl[0]` enable, `regctl[1]` file) that slot 1 reads through operand A (`regctl[3:2]`) or operand B (`regctl[5:4]`) in the same file with the same number. The exception is a slot-0 FP operation whose result is read only through operand B of a slot-1 store (`s1_flags[4]`): that pair is allowed.
- R5: An FP load (`flags[2]`, with an FP destination) in either slot is not paired with an FP operation in the other slot that reads the same FP register number through an FP operand when their half bits (`flags[3]`) differ.
- R6: An FP load and an FP operation in opposite slots that both write the same FP register number are not paired.
- R7: If either slot may set carry/borrow (`flags[0]`) while the other uses it (`flags[1]`), the pair is rejected.
- R8: When slot 0 may nullify its successor (`s0_flags[4]`), the pair is allowed only if slot 1 is class 0.
- R9: Completing a handshake whose last issued instruction (slot 1 if dual, else slot 0) is class 5 or 6 makes the next completed handshake single issue. The mark persists through cycles without a handshake and is cleared by the next handshake.
- R10: A pulse on `br_taken` marks the next window as a branch target. While marked, a window with odd `s0_pc` is single issue. The mark clears on the next handshake unless `br_taken` is high in that same cycle.
- R11: Reset leaves no delay-slot or branch-target mark, so the first window after reset pairs by R1 to R8 alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_valid | input | 1 | Window holds at least the slot-0 instruction |
| win_ready | output | 1 | Window is consumed this cycle if valid |
| s0_pc | input | PC_W | Word address of slot 0 |
| s0_cls | input | 4 | Class code of slot 0 |
| s0_dst | input | REG_W | Destination register of slot 0 |
| s0_src_a | input | REG_W | Operand A register of slot 0 |
| s0_src_b | input | REG_W | Operand B register of slot 0 |
| s0_regctl | input | 6 | {B file, B en, A file, A en, dst file, dst en}, file 1 = FP |
| s0_flags | input | 5 | {may nullify, FP half, FP load, carry use, carry set} |
| s1_valid | input | 1 | Slot 1 holds an instruction |
| s1_pc | input | PC_W | Word address of slot 1 |
| s1_cls | input | 4 | Class code of slot 1 |
| s1_dst | input | REG_W | Destination register of slot 1 |
| s1_src_a | input | REG_W | Operand A register of slot 1 |
| s1_src_b | input | REG_W | Operand B (store data) register of slot 1 |
| s1_regctl | input | 6 | Same layout as `s0_regctl` |
| s1_flags | input | 5 | {FP store, FP half, FP load, carry use, carry set} |
| br_taken | input | 1 | A taken branch redirects fetch; the next window is its target |
| iss_valid | output | 1 | Issue request |
| iss_ready | input | 1 | Issue side accepts |
| iss_dual | output | 1 | Both slots issue (else slot 0 only) |

## Verification
The pairing verdict and both handshake outputs are combinational, so they are due in the same cycle that the window is presented. The bench drives each window on the falling edge and samples the outputs two nanoseconds later. The delay-slot and branch-target marks change only on the rising edge after a completed handshake or a `br_taken` pulse, so their effect shows up on the window driven at the next falling edge. The bench's reference model updates its own copies of the two marks exactly at that rising edge. Directed windows with hand-computed verdicts come first, followed by a long run of random windows compared every cycle against the model.

// File: rtl/ipc_pkg.sv
package ipc_pkg;

  localparam int CLS_W = 4;

  typedef enum logic [CLS_W-1:0] {
    C_FLOP = 4'd0,
    C_LDST = 4'd1,
    C_ALU  = 4'd2,
    C_MM   = 4'd3,
    C_NUL  = 4'd4,
    C_VBR  = 4'd5,
    C_BR   = 4'd6,
    C_FTST = 4'd7,
    C_SYS  = 4'd8
  } icls_e;

  // flag bit positions shared by both slots
  localparam int F_CSET = 0;
  localparam int F_CUSE = 1;
  localparam int F_FPLD = 2;
  localparam int F_HALF = 3;
  localparam int F_SLOT = 4;  // slot 0: may nullify, slot 1: FP store

  // register control bit positions
  localparam int RC_DEN = 0;
  localparam int RC_DFP = 1;
  localparam int RC_AEN = 2;
  localparam int RC_AFP = 3;
  localparam int RC_BEN = 4;
  localparam int RC_BFP = 5;

  // set of second-slot classes allowed after a given first class
  function automatic logic [15:0] second_mask(input logic [CLS_W-1:0] first);
    logic [15:0] m;
    unique case (first)
      C_FLOP:  m = 16'h007E;
      C_LDST:  m = 16'h005D;
      C_ALU:   m = 16'h00DF;
      C_MM:    m = 16'h0087;
      C_NUL:   m = 16'h0001;
      default: m = 16'h0000;
    endcase
    return m;
  endfunction

  function automatic logic cls_is_branch(input logic [CLS_W-1:0] c);
    return (c == C_VBR) || (c == C_BR);
  endfunction

endpackage

// File: rtl/pair_class_matrix.sv
module pair_class_matrix
  import ipc_pkg::*;
(
  input  logic [CLS_W-1:0] cls0,
  input  logic [CLS_W-1:0] cls1,
  input  logic             null0,
  output logic             ok
);

  logic [15:0] row;
  logic        in_row;

  assign row    = second_mask(cls0);
  assign in_row = row[cls1];
  assign ok     = in_row & ~(null0 & (cls1 != C_FLOP));

endmodule

// File: rtl/pair_hazard.sv
module pair_hazard
  import ipc_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [CLS_W-1:0] cls0,
  input  logic [REG_W-1:0] dst0,
  input  logic [REG_W-1:0] sa0,
  input  logic [REG_W-1:0] sb0,
  input  logic [5:0]       rc0,
  input  logic [4:0]       fl0,
  input  logic [CLS_W-1:0] cls1,
  input  logic [REG_W-1:0] dst1,
  input  logic [REG_W-1:0] sa1,
  input  logic [REG_W-1:0] sb1,
  input  logic [5:0]       rc1,
  input  logic [4:0]       fl1,
  output logic             clash
);

  localparam int NSLOT = 2;

  logic [CLS_W-1:0] cls [NSLOT];
  logic [REG_W-1:0] dst [NSLOT];
  logic [REG_W-1:0] sa  [NSLOT];
  logic [REG_W-1:0] sb  [NSLOT];
  logic [5:0]       rc  [NSLOT];
  logic [4:0]       fl  [NSLOT];

  assign cls[0] = cls0;  assign cls[1] = cls1;
  assign dst[0] = dst0;  assign dst[1] = dst1;
  assign sa[0]  = sa0;   assign sa[1]  = sa1;
  assign sb[0]  = sb0;   assign sb[1]  = sb1;
  assign rc[0]  = rc0;   assign rc[1]  = rc1;
  assign fl[0]  = fl0;   assign fl[1]  = fl1;

  // read-after-write from slot 0 into slot 1
  logic hit_a, hit_b, fwd_store, raw;
  assign hit_a = rc0[RC_DEN] & rc1[RC_AEN] & (rc0[RC_DFP] == rc1[RC_AFP]) & (dst0 == sa1);
  assign hit_b = rc0[RC_DEN] & rc1[RC_BEN] & (rc0[RC_DFP] == rc1[RC_BFP]) & (dst0 == sb1);
  assign fwd_store = (cls0 == C_FLOP) & fl1[F_SLOT];
  assign raw = hit_a | (hit_b & ~fwd_store);

  // FP load in slot g against FP operation in the other slot
  logic [NSLOT-1:0] half_x;
  logic [NSLOT-1:0] same_t;

  for (genvar g = 0; g < NSLOT; g++) begin : g_ldop
    localparam int OP = NSLOT - 1 - g;
    logic ld, op, rd_a, rd_b;
    assign ld   = fl[g][F_FPLD] & rc[g][RC_DEN] & rc[g][RC_DFP];
    assign op   = (cls[OP] == C_FLOP);
    assign rd_a = rc[OP][RC_AEN] & rc[OP][RC_AFP] & (sa[OP] == dst[g]);
    assign rd_b = rc[OP][RC_BEN] & rc[OP][RC_BFP] & (sb[OP] == dst[g]);
    assign half_x[g] = ld & op & (rd_a | rd_b) & (fl[g][F_HALF] != fl[OP][F_HALF]);
    assign same_t[g] = ld & op & rc[OP][RC_DEN] & rc[OP][RC_DFP] & (dst[OP] == dst[g]);
  end

  logic carry;
  assign carry = (fl0[F_CSET] & fl1[F_CUSE]) | (fl1[F_CSET] & fl0[F_CUSE]);

  assign clash = raw | (|half_x) | (|same_t) | carry;

endmodule

// File: rtl/pair_ctx.sv
module pair_ctx (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic last_branch,
  input  logic br_taken,
  output logic delay_q,
  output logic target_q
);

  logic delay_d, delay_en;
  logic target_d, target_en;

  always_comb begin
    delay_en  = fire;
    delay_d   = last_branch;
    target_en = fire | br_taken;
    target_d  = br_taken;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      delay_q  <= 1'b0;
      target_q <= 1'b0;
    end else begin
      if (delay_en)  delay_q  <= delay_d;
      if (target_en) target_q <= target_d;
    end
  end

  p_delay_arm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && last_branch) |=> delay_q);

  p_delay_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(delay_q));

  p_target_arm_r10: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |=> target_q);

  p_target_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !br_taken) |=> !target_q);

endmodule

// File: rtl/pair_issue_gate.sv
module pair_issue_gate
  import ipc_pkg::*;
#(
  parameter int REG_W = 5,
  parameter int PC_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_valid,
  output logic             win_ready,
  input  logic [PC_W-1:0]  s0_pc,
  input  logic [CLS_W-1:0] s0_cls,
  input  logic [REG_W-1:0] s0_dst,
  input  logic [REG_W-1:0] s0_src_a,
  input  logic [REG_W-1:0] s0_src_b,
  input  logic [5:0]       s0_regctl,
  input  logic [4:0]       s0_flags,
  input  logic             s1_valid,
  input  logic [PC_W-1:0]  s1_pc,
  input  logic [CLS_W-1:0] s1_cls,
  input  logic [REG_W-1:0] s1_dst,
  input  logic [REG_W-1:0] s1_src_a,
  input  logic [REG_W-1:0] s1_src_b,
  input  logic [5:0]       s1_regctl,
  input  logic [4:0]       s1_flags,
  input  logic             br_taken,
  output logic             iss_valid,
  input  logic             iss_ready,
  output logic             iss_dual
);

  logic cls_ok, clash, adjacent, solo_ctx;
  logic delay_q, target_q, fire, last_branch;

  pair_class_matrix u_mat (
    .cls0  (s0_cls),
    .cls1  (s1_cls),
    .null0 (s0_flags[F_SLOT]),
    .ok    (cls_ok)
  );

  pair_hazard #(.REG_W(REG_W)) u_haz (
    .cls0 (s0_cls), .dst0 (s0_dst), .sa0 (s0_src_a), .sb0 (s0_src_b),
    .rc0  (s0_regctl), .fl0 (s0_flags),
    .cls1 (s1_cls), .dst1 (s1_dst), .sa1 (s1_src_a), .sb1 (s1_src_b),
    .rc1  (s1_regctl), .fl1 (s1_flags),
    .clash (clash)
  );

  pair_ctx u_ctx (
    .clk         (clk),
    .rst_n       (rst_n),
    .fire        (fire),
    .last_branch (last_branch),
    .br_taken    (br_taken),
    .delay_q     (delay_q),
    .target_q    (target_q)
  );

  assign adjacent    = (s1_pc == s0_pc + PC_W'(1));
  assign solo_ctx    = delay_q | (target_q & s0_pc[0]);
  assign iss_dual    = win_valid & s1_valid & adjacent & cls_ok & ~clash & ~solo_ctx;
  assign iss_valid   = win_valid;
  assign win_ready   = iss_ready;
  assign fire        = win_valid & iss_ready;
  assign last_branch = iss_dual ? cls_is_branch(s1_cls) : cls_is_branch(s0_cls);

  p_pair_adjacent_r1: assert property (@(posedge clk) disable iff (!rst_n)
    iss_dual |-> (win_valid && s1_valid && (s1_pc == s0_pc + PC_W'(1))));

  p_sys_solo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((s0_cls == C_SYS) || (s1_cls == C_SYS)) |-> !iss_dual);

  p_carry_solo_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((s0_flags[F_CSET] && s1_flags[F_CUSE]) || (s1_flags[F_CSET] && s0_flags[F_CUSE]))
      |-> !iss_dual);

  p_null_solo_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (s0_flags[F_SLOT] && (s1_cls != C_FLOP)) |-> !iss_dual);

  p_delay_solo_r9: assert property (@(posedge clk) disable iff (!rst_n)
    delay_q |-> !iss_dual);

  p_target_solo_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (target_q && s0_pc[0]) |-> !iss_dual);

endmodule

// File: tb/test_pair_issue_gate.sv
module test_pair_issue_gate;

  localparam int REG_W = 5;
  localparam int PC_W  = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic win_valid, win_ready, s1_valid, br_taken, iss_valid, iss_ready, iss_dual;
  logic [PC_W-1:0]  s0_pc, s1_pc;
  logic [3:0]       s0_cls, s1_cls;
  logic [REG_W-1:0] s0_dst, s0_src_a, s0_src_b, s1_dst, s1_src_a, s1_src_b;
  logic [5:0]       s0_regctl, s1_regctl;
  logic [4:0]       s0_flags, s1_flags;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;
  bit m_delay, m_target;

  always #5 clk = ~clk;

  pair_issue_gate #(.REG_W(REG_W), .PC_W(PC_W)) i_pair_issue_gate (
    .clk(clk), .rst_n(rst_n), .win_valid(win_valid), .win_ready(win_ready),
    .s0_pc(s0_pc), .s0_cls(s0_cls), .s0_dst(s0_dst), .s0_src_a(s0_src_a),
    .s0_src_b(s0_src_b), .s0_regctl(s0_regctl), .s0_flags(s0_flags),
    .s1_valid(s1_valid), .s1_pc(s1_pc), .s1_cls(s1_cls), .s1_dst(s1_dst),
    .s1_src_a(s1_src_a), .s1_src_b(s1_src_b), .s1_regctl(s1_regctl),
    .s1_flags(s1_flags), .br_taken(br_taken), .iss_valid(iss_valid),
    .iss_ready(iss_ready), .iss_dual(iss_dual)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit allowed(input int c0, input int c1);
    case (c0)
      0: return c1 inside {1, 2, 3, 4, 5, 6};
      1: return c1 inside {0, 2, 3, 4, 6};
      2: return c1 inside {0, 1, 2, 3, 4, 6, 7};
      3: return c1 inside {0, 1, 2, 7};
      4: return c1 == 0;
      default: return 0;
    endcase
  endfunction

  // reference model: 0 = pair, otherwise number of the rule that forbids it
  function automatic int why();
    logic [PC_W-1:0] nxt;
    int cls [2];
    int dst [2];
    int src [2][2];
    logic [5:0] rc [2];
    logic [4:0] fl [2];
    nxt = s0_pc + 1'b1;
    if (!win_valid || !s1_valid || s1_pc != nxt) return 1;
    if (m_delay) return 9;
    if (m_target && s0_pc[0]) return 10;
    if (s0_cls == 8 || s1_cls == 8) return 3;
    if (!allowed(s0_cls, s1_cls)) return 2;
    if (s0_flags[4] && s1_cls != 0) return 8;
    for (int k = 0; k < 2; k++) begin
      int r = (k == 0) ? int'(s1_src_a) : int'(s1_src_b);
      if (s0_regctl[0] && s1_regctl[2+2*k] && (s1_regctl[3+2*k] == s0_regctl[1])
          && r == s0_dst && !(k == 1 && s0_cls == 0 && s1_flags[4]))
        return 4;
    end
    cls[0] = s0_cls; cls[1] = s1_cls; dst[0] = s0_dst; dst[1] = s1_dst;
    src[0][0] = s0_src_a; src[0][1] = s0_src_b; src[1][0] = s1_src_a; src[1][1] = s1_src_b;
    rc[0] = s0_regctl; rc[1] = s1_regctl; fl[0] = s0_flags; fl[1] = s1_flags;
    for (int l = 0; l < 2; l++) begin
      int o = 1 - l;
      if (fl[l][2] && rc[l][0] && rc[l][1] && cls[o] == 0) begin
        for (int k = 0; k < 2; k++)
          if (rc[o][2+2*k] && rc[o][3+2*k] && src[o][k] == dst[l] && fl[l][3] != fl[o][3])
            return 5;
        if (rc[o][0] && rc[o][1] && dst[o] == dst[l]) return 6;
      end
    end
    if ((s0_flags[0] && s1_flags[1]) || (s1_flags[0] && s0_flags[1])) return 7;
    return 0;
  endfunction

  function automatic string tagname(input int w);
    case (w)
      1: return "R1";  3: return "R3";  4: return "R4";  5: return "R5";
      6: return "R6";  7: return "R7";  8: return "R8";  9: return "R9";
      10: return "R10";
      default: return "R2";
    endcase
  endfunction

  task automatic cycle(input string tag, input bit exp);
    bit fire;
    int last;
    #2;
    chk(tag, iss_dual, exp);
    chk("R1", iss_valid, win_valid);
    chk("R1", win_ready, iss_ready);
    fire = win_valid && iss_ready;
    last = exp ? int'(s1_cls) : int'(s0_cls);
    @(posedge clk);
    if (fire) begin
      m_delay  = (last == 5 || last == 6);
      m_target = br_taken;
    end else if (br_taken) m_target = 1;
    @(negedge clk);
  endtask

  task automatic clean();
    win_valid = 1; s1_valid = 1; iss_ready = 1; br_taken = 0;
    s0_pc = 16'd4; s1_pc = 16'd5;
    s0_cls = 4'd2; s1_cls = 4'd2;
    s0_dst = 5'd1; s0_src_a = 5'd2; s0_src_b = 5'd3; s0_regctl = 6'b010101;
    s1_dst = 5'd4; s1_src_a = 5'd5; s1_src_b = 5'd6; s1_regctl = 6'b010101;
    s0_flags = '0; s1_flags = '0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; m_delay = 0; m_target = 0;
    clean();
    win_valid = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R11: no marks after reset, odd start pairs
    clean(); s0_pc = 16'd5; s1_pc = 16'd6;
    cycle("R11", 1);
    // R1: handshake and window shape
    clean(); s1_valid = 0;            cycle("R1", 0);
    clean(); s1_pc = 16'd7;           cycle("R1", 0);
    clean(); win_valid = 0;           cycle("R1", 0);
    clean(); iss_ready = 0;           cycle("R1", 1);
    // R2: class matrix
    clean(); s0_cls = 0; s1_cls = 1;  cycle("R2", 1);
    clean(); s0_cls = 1; s1_cls = 1;  cycle("R2", 0);
    clean(); s0_cls = 3; s1_cls = 6;  cycle("R2", 0);
    clean(); s0_cls = 2; s1_cls = 7;  cycle("R2", 1);
    clean(); s0_cls = 7; s1_cls = 2;  cycle("R2", 0);
    // R3: system class
    clean(); s1_cls = 8;              cycle("R3", 0);
    clean(); s0_cls = 8;              cycle("R3", 0);
    // R4: read after write and store exception
    clean(); s1_src_a = 5'd1;         cycle("R4", 0);
    clean(); s1_src_b = 5'd1;         cycle("R4", 0);
    clean(); s0_cls = 0; s0_dst = 5'd7; s0_regctl = 6'b000011;
    s1_cls = 1; s1_flags[4] = 1; s1_src_a = 5'd7; s1_src_b = 5'd7; s1_regctl = 6'b110100;
    cycle("R4", 1);
    clean(); s0_cls = 0; s0_dst = 5'd7; s0_regctl = 6'b000011;
    s1_cls = 1; s1_src_b = 5'd7; s1_regctl = 6'b110100;
    cycle("R4", 0);
    clean(); s0_dst = 5'd7; s1_src_a = 5'd7; s1_regctl = 6'b011101;
    cycle("R4", 1);
    // R5: load half against FP op reading the other half
    clean(); s0_cls = 0; s0_src_a = 5'd8; s0_dst = 5'd9; s0_regctl = 6'b001111; s0_flags[3] = 1;
    s1_cls = 1; s1_dst = 5'd8; s1_regctl = 6'b010111; s1_flags[2] = 1;
    cycle("R5", 0);
    clean(); s0_cls = 0; s0_src_a = 5'd8; s0_dst = 5'd9; s0_regctl = 6'b001111; s0_flags[3] = 1;
    s1_cls = 1; s1_dst = 5'd8; s1_regctl = 6'b010111; s1_flags[2] = 1; s1_flags[3] = 1;
    cycle("R5", 1);
    // R6: same FP target
    clean(); s0_cls = 0; s0_dst = 5'd10; s0_src_a = 5'd11; s0_src_b = 5'd12; s0_regctl = 6'b111111;
    s1_cls = 1; s1_dst = 5'd10; s1_regctl = 6'b010111; s1_flags[2] = 1;
    cycle("R6", 0);
    // R7: carry producer and consumer
    clean(); s0_flags[0] = 1; s1_flags[1] = 1; cycle("R7", 0);
    clean(); s0_flags[1] = 1; s1_flags[0] = 1; cycle("R7", 0);
    clean(); s0_flags[0] = 1; s1_flags[0] = 1; cycle("R7", 1);
    // R8: may-nullify first
    clean(); s0_flags[4] = 1;               cycle("R8", 0);
    clean(); s0_flags[4] = 1; s1_cls = 0;   cycle("R8", 1);
    // R9: delay slot after a paired branch
    clean(); s1_cls = 6;       cycle("R9", 1);
    clean();                   cycle("R9", 0);
    clean();                   cycle("R9", 1);
    clean(); s1_cls = 6;       cycle("R9", 1);
    clean(); iss_ready = 0;    cycle("R9", 0);
    clean(); iss_ready = 0;    cycle("R9", 0);
    clean();                   cycle("R9", 0);
    clean();                   cycle("R9", 1);
    // R10: taken-branch target at odd and even word address
    clean(); win_valid = 0; br_taken = 1;     cycle("R10", 0);
    clean(); s0_pc = 16'd9; s1_pc = 16'd10;   cycle("R10", 0);
    clean(); s0_pc = 16'd9; s1_pc = 16'd10;   cycle("R10", 1);
    clean(); win_valid = 0; br_taken = 1;     cycle("R10", 0);
    clean(); s0_pc = 16'd10; s1_pc = 16'd11;  cycle("R10", 1);

    // random windows against the reference model
    for (int i = 0; i < 4000; i++) begin
      int w;
      win_valid = ($urandom % 8) != 0;
      s1_valid  = ($urandom % 8) != 0;
      iss_ready = ($urandom % 5) != 0;
      br_taken  = ($urandom % 10) == 0;
      s0_pc     = PC_W'($urandom);
      s1_pc     = (($urandom % 6) == 0) ? PC_W'($urandom) : s0_pc + 1'b1;
      s0_cls    = 4'($urandom % 10);
      s1_cls    = 4'($urandom % 10);
      s0_dst    = 5'($urandom % 4); s0_src_a = 5'($urandom % 4); s0_src_b = 5'($urandom % 4);
      s1_dst    = 5'($urandom % 4); s1_src_a = 5'($urandom % 4); s1_src_b = 5'($urandom % 4);
      s0_regctl = 6'($urandom);     s1_regctl = 6'($urandom);
      s0_flags  = 5'($urandom & $urandom);
      s1_flags  = 5'($urandom & $urandom);
      w = why();
      cycle(tagname(w), w == 0);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule